// File: doc/BRIEF.md
# Synchronisation-Cell Window Map and Access Decoder

This block owns the two software-visible map registers that place a window of synchronisation cells in the storage address space. Each register is 64 bits wide and sits on a small tag bus. The block derives the window's base address, size and enable state from these registers. It then decodes every storage-bus access that falls inside the window into a cell number and a view code. The view code is one of six access semantics that the cell array applies to the same cell: raw data, tag/control, empty/full with wait, empty/full polling, semaphore with wait, and semaphore polling.

Cells are spaced at a programmable power-of-two stride. The low bits of each cell's slot choose the view instead of a word offset. The block registers the decoded access for one cycle, then drives a read or write strobe, the cell select, the view and the write data to the cell array. Read data from the array comes back to the storage port in that same cycle. The block also reports the number of implemented cells and whether the selected cell is a FIFO cell. FIFO cells come first in the numbering, and semaphore cells follow them.

Top module: `itc_map_decoder`

## Requirements
- R1: After reset, map register 0 reads 0 and the window is disabled with base 0. The window size is 4096 bytes. Map register 1 reads 0xC00 plus the implemented cell count placed at bit 20 and up (grain 0). The count output equals the number of FIFO cells plus the number of semaphore cells.
- R2: A tag read returns its data with tag_rvalid one cycle after the request. The register index is tag_addr shifted right by 3. Indices 2 and above read as 0.
- R3: A write to map register 0 updates only the base field (bits 31:10) and the enable bit (bit 0). All other bits read back unchanged, and the base and enable take effect on the next cycle.
- R4: A write to map register 1 updates only the mask field (bits 16:10) and the grain field (bits 2:0). The cell count field is never changed. Tag writes to indices 2 and above change nothing.
- R5: The window size is 1024 plus the mask field, counted in bytes. A new size is applied only if it is a power of two. Otherwise the previous size stays, although the field still reads back the written value.
- R6: An access hits only when the window is enabled and base <= address <= base+size-1. A miss drives no cell strobe, and a read that misses returns 0.
- R7: The cell select equals (address - base) >> (7 + grain). Any value above the last implemented cell is clamped to that last cell.
- R8: The view code is bits 6:3 of (address - base). The codes mean: 0 raw, 1 tag, 2 empty/full wait, 3 empty/full poll, 4 semaphore wait, 5 semaphore poll. Codes 6 to 15 give no strobe: a read returns all ones and a write is dropped.
- R9: A hit with a valid view drives exactly one strobe, one cycle after st_valid. In that cycle cell_sel, cell_view and cell_wdata hold the decoded access. For a read, st_rvalid is asserted in that cycle with st_rdata equal to cell_rdata.
- R10: cell_is_fifo is 1 exactly when the selected cell number is below the number of FIFO cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_valid | input | 1 | Tag-bus request |
| tag_write | input | 1 | Tag request is a write |
| tag_addr | input | TAG_AW | Tag byte address |
| tag_wdata | input | 64 | Tag write data |
| tag_rvalid | output | 1 | Tag read data valid |
| tag_rdata | output | 64 | Tag read data |
| st_valid | input | 1 | Storage access request |
| st_write | input | 1 | Storage access is a write |
| st_addr | input | 32 | Storage byte address |
| st_wdata | input | 64 | Storage write data |
| st_rvalid | output | 1 | Storage read response valid |
| st_rdata | output | 64 | Storage read response |
| cell_rd_stb | output | 1 | Read strobe to the cell array |
| cell_wr_stb | output | 1 | Write strobe to the cell array |
| cell_sel | output | CELL_W | Selected cell number |
| cell_view | output | 4 | Access view code |
| cell_wdata | output | 64 | Write data to the cell array |
| cell_is_fifo | output | 1 | Selected cell is a FIFO cell |
| cell_rdata | input | 64 | Read data from the cell array |
| win_base | output | 32 | Window base address |
| win_size | output | 18 | Window size in bytes |
| win_en | output | 1 | Window enabled |
| num_cells | output | 6 | Implemented cell count |

## Verification
The results have two timings. Tag read data, the window outputs after a tag write, and the cell strobe with its select, view and read response all settle one clock edge after the request. The only exception is the response, which is combinational from that registered stage and cell_rdata. The bench drives each request on a falling edge and releases it on the next falling edge. It samples every result at that second falling edge, which is exactly one rising edge after the request. It then checks that the strobes have dropped one cycle later. The near-exhaustive sweep covers every grain, six cell slots (two past the clamp) and all sixteen view codes. The model cell array echoes the select and view in its read data, so every response also confirms the decode.

// File: rtl/itcmd_pkg.sv
package itcmd_pkg;

  localparam int unsigned MAP_REGS   = 2;
  localparam int unsigned MIN_SHIFT  = 7;
  localparam int unsigned RESET_WIN  = 4096;
  localparam int unsigned VIEW_LAST  = 5;

  typedef enum logic [3:0] {
    VW_RAW      = 4'd0,
    VW_TAG      = 4'd1,
    VW_EF_WAIT  = 4'd2,
    VW_EF_POLL  = 4'd3,
    VW_SEM_WAIT = 4'd4,
    VW_SEM_POLL = 4'd5
  } view_e;

  // Window size in bytes from the 7-bit mask field (bits 16:10 of the register).
  function automatic logic [17:0] size_of_mask(input logic [6:0] mask);
    return 18'd1024 + {1'b0, mask, 10'd0};
  endfunction

  function automatic logic is_pow2(input logic [17:0] v);
    return (v != 18'd0) && ((v & (v - 18'd1)) == 18'd0);
  endfunction

  function automatic logic [3:0] stride_shift(input logic [2:0] grain);
    return 4'(MIN_SHIFT) + {1'b0, grain};
  endfunction

  function automatic logic [31:0] cell_of(input logic [31:0] off,
                                          input logic [2:0]  grain,
                                          input int unsigned ncells);
    logic [31:0] raw;
    raw = off >> stride_shift(grain);
    return (raw >= ncells) ? (ncells - 1) : raw;
  endfunction

  function automatic logic view_known(input logic [3:0] v);
    return v <= 4'(VIEW_LAST);
  endfunction

endpackage

// File: rtl/itcmd_map_regs.sv
module itcmd_map_regs
  import itcmd_pkg::*;
#(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned TAG_AW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_valid,
  input  logic              tag_write,
  input  logic [TAG_AW-1:0] tag_addr,
  input  logic [63:0]       tag_wdata,
  output logic              tag_rvalid,
  output logic [63:0]       tag_rdata,
  output logic [31:0]       win_base,
  output logic [17:0]       win_size,
  output logic              win_en,
  output logic [2:0]        grain
);

  localparam int unsigned IDX_W    = TAG_AW - 3;
  localparam logic [6:0]  RST_MASK = 7'(((RESET_WIN - 1) >> 10) & 32'h7F);

  logic [IDX_W-1:0] idx;
  logic [21:0]      base_q;
  logic             en_q;
  logic [6:0]       mask_q;
  logic [2:0]       grain_q;
  logic [17:0]      size_q;
  logic [63:0]      rd_val;
  logic [17:0]      new_size;
  logic             wr0, wr1;
  logic             unused_tag;

  assign idx      = tag_addr[TAG_AW-1:3];
  assign wr0      = tag_valid && tag_write && (idx == IDX_W'(0));
  assign wr1      = tag_valid && tag_write && (idx == IDX_W'(1));
  assign new_size = size_of_mask(tag_wdata[16:10]);
  assign unused_tag = ^{tag_addr[2:0], tag_wdata[63:32], tag_wdata[9:3]};

  always_comb begin
    case (idx)
      IDX_W'(0): rd_val = {32'd0, base_q, 9'd0, en_q};
      IDX_W'(1): rd_val = (64'(N_CELLS) << 20) | {47'd0, mask_q, 7'd0, grain_q};
      default:   rd_val = 64'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      en_q       <= 1'b0;
      mask_q     <= RST_MASK;
      grain_q    <= 3'd0;
      size_q     <= size_of_mask(RST_MASK);
      tag_rvalid <= 1'b0;
      tag_rdata  <= '0;
    end else begin
      tag_rvalid <= tag_valid && !tag_write;
      if (tag_valid && !tag_write) tag_rdata <= rd_val;
      if (wr0) begin
        base_q <= tag_wdata[31:10];
        en_q   <= tag_wdata[0];
      end
      if (wr1) begin
        mask_q  <= tag_wdata[16:10];
        grain_q <= tag_wdata[2:0];
        if (is_pow2(new_size)) size_q <= new_size;
      end
    end
  end

  assign win_base = {base_q, 10'd0};
  assign win_size = size_q;
  assign win_en   = en_q;
  assign grain    = grain_q;

endmodule

// File: rtl/itcmd_addr_decode.sv
module itcmd_addr_decode
  import itcmd_pkg::*;
#(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned CELL_W  = 2
) (
  input  logic [31:0]       st_addr,
  input  logic [31:0]       win_base,
  input  logic [17:0]       win_size,
  input  logic              win_en,
  input  logic [2:0]        grain,
  output logic              hit,
  output logic [CELL_W-1:0] cell_idx,
  output logic [3:0]        view,
  output logic              view_ok
);

  logic [31:0] offset;

  assign offset   = st_addr - win_base;
  assign hit      = win_en && (st_addr >= win_base) && (offset < {14'd0, win_size});
  assign cell_idx = CELL_W'(cell_of(offset, grain, N_CELLS));
  assign view     = offset[6:3];
  assign view_ok  = view_known(view);

endmodule

// File: rtl/itcmd_access_stage.sv
module itcmd_access_stage #(
  parameter int unsigned CELL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic              in_hit,
  input  logic              in_vok,
  input  logic [CELL_W-1:0] in_cell,
  input  logic [3:0]        in_view,
  input  logic [63:0]       in_wdata,
  output logic              q_valid,
  output logic              q_write,
  output logic              q_hit,
  output logic              q_vok,
  output logic [CELL_W-1:0] q_cell,
  output logic [3:0]        q_view,
  output logic [63:0]       q_wdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_write <= 1'b0;
      q_hit   <= 1'b0;
      q_vok   <= 1'b0;
      q_cell  <= '0;
      q_view  <= '0;
      q_wdata <= '0;
    end else begin
      q_valid <= in_valid;
      q_write <= in_write;
      q_hit   <= in_hit;
      q_vok   <= in_vok;
      if (in_valid) begin
        q_cell  <= in_cell;
        q_view  <= in_view;
        q_wdata <= in_wdata;
      end
    end
  end

endmodule

// File: rtl/itc_map_decoder.sv
module itc_map_decoder
  import itcmd_pkg::*;
#(
  parameter int unsigned N_FIFO = 16,
  parameter int unsigned N_SEM  = 16,
  parameter int unsigned TAG_AW = 6,
  localparam int unsigned N_CELLS = N_FIFO + N_SEM,
  localparam int unsigned CELL_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_valid,
  input  logic              tag_write,
  input  logic [TAG_AW-1:0] tag_addr,
  input  logic [63:0]       tag_wdata,
  output logic              tag_rvalid,
  output logic [63:0]       tag_rdata,
  input  logic              st_valid,
  input  logic              st_write,
  input  logic [31:0]       st_addr,
  input  logic [63:0]       st_wdata,
  output logic              st_rvalid,
  output logic [63:0]       st_rdata,
  output logic              cell_rd_stb,
  output logic              cell_wr_stb,
  output logic [CELL_W-1:0] cell_sel,
  output logic [3:0]        cell_view,
  output logic [63:0]       cell_wdata,
  output logic              cell_is_fifo,
  input  logic [63:0]       cell_rdata,
  output logic [31:0]       win_base,
  output logic [17:0]       win_size,
  output logic              win_en,
  output logic [5:0]        num_cells
);

  logic [2:0]        grain;
  logic              dec_hit;
  logic [CELL_W-1:0] dec_cell;
  logic [3:0]        dec_view;
  logic              dec_vok;
  logic              q_valid, q_write, q_hit, q_vok;

  itcmd_map_regs #(.N_CELLS(N_CELLS), .TAG_AW(TAG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .tag_valid(tag_valid), .tag_write(tag_write), .tag_addr(tag_addr),
    .tag_wdata(tag_wdata), .tag_rvalid(tag_rvalid), .tag_rdata(tag_rdata),
    .win_base(win_base), .win_size(win_size), .win_en(win_en), .grain(grain)
  );

  itcmd_addr_decode #(.N_CELLS(N_CELLS), .CELL_W(CELL_W)) u_dec (
    .st_addr(st_addr), .win_base(win_base), .win_size(win_size),
    .win_en(win_en), .grain(grain),
    .hit(dec_hit), .cell_idx(dec_cell), .view(dec_view), .view_ok(dec_vok)
  );

  itcmd_access_stage #(.CELL_W(CELL_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(st_valid), .in_write(st_write), .in_hit(dec_hit),
    .in_vok(dec_vok), .in_cell(dec_cell), .in_view(dec_view),
    .in_wdata(st_wdata),
    .q_valid(q_valid), .q_write(q_write), .q_hit(q_hit), .q_vok(q_vok),
    .q_cell(cell_sel), .q_view(cell_view), .q_wdata(cell_wdata)
  );

  assign cell_rd_stb  = q_valid && !q_write && q_hit && q_vok;
  assign cell_wr_stb  = q_valid &&  q_write && q_hit && q_vok;
  assign st_rvalid    = q_valid && !q_write;
  assign st_rdata     = !q_hit ? 64'd0 : (!q_vok ? '1 : cell_rdata);
  assign cell_is_fifo = 32'(cell_sel) < N_FIFO;
  assign num_cells    = 6'(N_CELLS);

endmodule

// File: rtl/itcmd_checker.sv
module itcmd_checker #(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned CELL_W  = 2,
  parameter int unsigned TAG_AW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tag_valid,
  input logic              tag_write,
  input logic [TAG_AW-1:0] tag_addr,
  input logic              st_valid,
  input logic              st_write,
  input logic              dec_hit,
  input logic              st_rvalid,
  input logic [63:0]       st_rdata,
  input logic              cell_rd_stb,
  input logic              cell_wr_stb,
  input logic [CELL_W-1:0] cell_sel,
  input logic [31:0]       win_base,
  input logic [17:0]       win_size,
  input logic              win_en
);

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_rd_stb && cell_wr_stb));

  assert_strobe_follows_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_rd_stb || cell_wr_stb) |-> $past(st_valid));

  assert_sel_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_rd_stb || cell_wr_stb) |-> (32'(cell_sel) < N_CELLS));

  assert_size_pow2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_size) == 1);

  assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !dec_hit) |=> (!cell_rd_stb && !cell_wr_stb));

  assert_miss_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_write && !dec_hit) |=> (st_rvalid && st_rdata == 64'd0));

  assert_ignored_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_write && (32'(tag_addr[TAG_AW-1:3]) >= 2))
      |=> ($stable(win_base) && $stable(win_en) && $stable(win_size)));

endmodule

bind itc_map_decoder itcmd_checker #(
  .N_CELLS(N_CELLS), .CELL_W(CELL_W), .TAG_AW(TAG_AW)
) u_chk (.*);

// File: tb/itc_map_decoder_bench.sv
module itc_map_decoder_bench;

  localparam int unsigned NF = 2;
  localparam int unsigned NS = 2;
  localparam int unsigned NC = NF + NS;
  localparam int unsigned CW = 2;
  localparam int unsigned TAW = 6;
  localparam logic [31:0] BASE = 32'h0004_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tag_valid = 1'b0, tag_write = 1'b0;
  logic [TAW-1:0] tag_addr = '0;
  logic [63:0] tag_wdata = '0;
  logic tag_rvalid;
  logic [63:0] tag_rdata;
  logic st_valid = 1'b0, st_write = 1'b0;
  logic [31:0] st_addr = '0;
  logic [63:0] st_wdata = '0;
  logic st_rvalid;
  logic [63:0] st_rdata;
  logic cell_rd_stb, cell_wr_stb, cell_is_fifo;
  logic [CW-1:0] cell_sel;
  logic [3:0] cell_view;
  logic [63:0] cell_wdata, cell_rdata;
  logic [31:0] win_base;
  logic [17:0] win_size;
  logic win_en;
  logic [5:0] num_cells;

  int vectors = 0;
  int miscompares = 0;
  logic [63:0] rv;

  always #10 clk = ~clk;

  // Model cell array: read data echoes the select and the view.
  assign cell_rdata = {16'hC311, 32'd0, 8'(cell_sel), 4'd0, cell_view};

  itc_map_decoder #(.N_FIFO(NF), .N_SEM(NS), .TAG_AW(TAW)) u_itc_map_decoder (
    .clk(clk), .rst_n(rst_n),
    .tag_valid(tag_valid), .tag_write(tag_write), .tag_addr(tag_addr),
    .tag_wdata(tag_wdata), .tag_rvalid(tag_rvalid), .tag_rdata(tag_rdata),
    .st_valid(st_valid), .st_write(st_write), .st_addr(st_addr),
    .st_wdata(st_wdata), .st_rvalid(st_rvalid), .st_rdata(st_rdata),
    .cell_rd_stb(cell_rd_stb), .cell_wr_stb(cell_wr_stb), .cell_sel(cell_sel),
    .cell_view(cell_view), .cell_wdata(cell_wdata), .cell_is_fifo(cell_is_fifo),
    .cell_rdata(cell_rdata), .win_base(win_base), .win_size(win_size),
    .win_en(win_en), .num_cells(num_cells)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tag_wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    tag_valid = 1'b1; tag_write = 1'b1; tag_addr = TAW'(idx << 3); tag_wdata = d;
    @(negedge clk);
    tag_valid = 1'b0; tag_write = 1'b0;
  endtask

  task automatic tag_rd(input int idx, output logic [63:0] d);
    @(negedge clk);
    tag_valid = 1'b1; tag_write = 1'b0; tag_addr = TAW'(idx << 3);
    @(negedge clk);
    chk("R2 rvalid", {63'd0, tag_rvalid}, 64'd1);
    d = tag_rdata;
    tag_valid = 1'b0;
  endtask

  // Drive one storage access; outputs are sampled one rising edge later.
  task automatic st_go(input logic wr, input logic [31:0] a, input logic [63:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_write = wr; st_addr = a; st_wdata = d;
    @(negedge clk);
    st_valid = 1'b0; st_write = 1'b0;
  endtask

  function automatic logic [63:0] echo(input int c, input int v);
    return {16'hC311, 32'd0, 8'(c), 4'd0, 4'(v)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 win_en", {63'd0, win_en}, 64'd0);
    chk("R1 win_base", {32'd0, win_base}, 64'd0);
    chk("R1 win_size", {46'd0, win_size}, 64'd4096);
    chk("R1 num_cells", {58'd0, num_cells}, 64'(NC));
    tag_rd(0, rv); chk("R1 reg0", rv, 64'd0);
    tag_rd(1, rv); chk("R1 reg1", rv, 64'h0C00 | (64'(NC) << 20));
    // R2 unimplemented indices
    for (int i = 2; i < 8; i++) begin
      tag_rd(i, rv); chk("R2 high index", rv, 64'd0);
    end
    // R3 write mask of register 0
    tag_wr(0, '1);
    chk("R3 win_base", {32'd0, win_base}, 64'hFFFF_FC00);
    chk("R3 win_en", {63'd0, win_en}, 64'd1);
    tag_rd(0, rv); chk("R3 reg0", rv, 64'hFFFF_FC01);
    // R4 write mask of register 1, R5 size
    tag_wr(1, '1);
    tag_rd(1, rv); chk("R4 reg1", rv, 64'h1FC07 | (64'(NC) << 20));
    chk("R5 size max", {46'd0, win_size}, 64'h20000);
    // R4 ignored index
    tag_wr(3, 64'd0);
    tag_rd(0, rv); chk("R4 idx3 reg0", rv, 64'hFFFF_FC01);
    tag_rd(1, rv); chk("R4 idx3 reg1", rv, 64'h1FC07 | (64'(NC) << 20));
    chk("R4 idx3 size", {46'd0, win_size}, 64'h20000);
    // R5 non-power-of-two size not applied, field still reads back
    tag_wr(1, 64'h800);
    chk("R5 3K ignored", {46'd0, win_size}, 64'h20000);
    tag_rd(1, rv); chk("R5 reg1 readback", rv, 64'h800 | (64'(NC) << 20));
    tag_wr(1, 64'h400);
    chk("R5 2K applied", {46'd0, win_size}, 64'd2048);
    // R6 disabled window
    tag_wr(0, {32'd0, BASE});
    tag_wr(1, 64'h1FC00);
    st_go(1'b0, BASE, 64'd0);
    chk("R6 disabled rvalid", {63'd0, st_rvalid}, 64'd1);
    chk("R6 disabled strobe", {63'd0, cell_rd_stb}, 64'd0);
    chk("R6 disabled data", st_rdata, 64'd0);
    // R6 boundaries (size 128K, grain 0)
    tag_wr(0, {32'd0, BASE} | 64'd1);
    st_go(1'b0, BASE - 32'd8, 64'd0);
    chk("R6 below base", st_rdata, 64'd0);
    chk("R6 below base stb", {63'd0, cell_rd_stb}, 64'd0);
    st_go(1'b0, BASE + 32'h20000 - 32'd8, 64'd0);
    chk("R6 last byte hit view15", st_rdata, '1);
    st_go(1'b0, BASE + 32'h20000, 64'd0);
    chk("R6 above top", st_rdata, 64'd0);
    st_go(1'b0, BASE + 32'h20000 - 32'd48, 64'd0);
    chk("R6 last slot view10", st_rdata, '1);
    st_go(1'b0, BASE + 32'h1FF80 + 32'd40, 64'd0);
    chk("R6 top slot view5", st_rdata, echo(NC - 1, 5));
    // R7 R8 R10 sweep over grain, cell slot and view
    for (int g = 0; g < 8; g++) begin
      tag_wr(1, 64'h1FC00 | 64'(g));
      for (int k = 0; k < 6; k++) begin
        for (int v = 0; v < 16; v++) begin
          int ec;
          ec = (k >= NC) ? NC - 1 : k;
          st_go(1'b0, BASE + 32'(k * (128 << g)) + 32'(v * 8), 64'd0);
          chk("R9 read rvalid", {63'd0, st_rvalid}, 64'd1);
          if (v <= 5) begin
            chk("R8 read strobe", {63'd0, cell_rd_stb}, 64'd1);
            chk("R7 R8 echo data", st_rdata, echo(ec, v));
            chk("R10 fifo flag", {63'd0, cell_is_fifo}, {63'd0, ec < NF});
          end else begin
            chk("R8 unknown view strobe", {63'd0, cell_rd_stb}, 64'd0);
            chk("R8 unknown view data", st_rdata, '1);
          end
        end
      end
    end
    // R9 write path and strobe timing
    tag_wr(1, 64'h1FC00);
    st_go(1'b1, BASE + 32'd128 + 32'd16, 64'hDEAD_BEEF_0123_4567);
    chk("R9 wr strobe", {63'd0, cell_wr_stb}, 64'd1);
    chk("R9 rd strobe low", {63'd0, cell_rd_stb}, 64'd0);
    chk("R9 wr rvalid low", {63'd0, st_rvalid}, 64'd0);
    chk("R9 wr sel", 64'(cell_sel), 64'd1);
    chk("R9 wr view", 64'(cell_view), 64'd2);
    chk("R9 wr data", cell_wdata, 64'hDEAD_BEEF_0123_4567);
    @(negedge clk);
    chk("R9 strobe one cycle", {62'd0, cell_wr_stb, cell_rd_stb}, 64'd0);
    st_go(1'b1, BASE + 32'd256 + 32'd56, 64'h1);
    chk("R8 unknown view write dropped", {63'd0, cell_wr_stb}, 64'd0);
    st_go(1'b1, BASE + 32'h20000, 64'h1);
    chk("R6 miss write dropped", {63'd0, cell_wr_stb}, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule